// File: doc/BRIEF.md
# ADC Host Register Interface with Interrupt

This block is a byte-wide bus slave between a host processor and a multi-channel successive-approximation converter. The host starts a conversion by writing a channel number. Nothing else has to be written to start it. A busy flag then shows that the conversion is running. When the conversion ends, the block stores the result and can raise a level-sensitive interrupt. The host reads the result as a high byte and then a low byte. Reading the low byte acknowledges the interrupt.

The block also has a small bank of byte-wide output registers that drive digital-to-analog converter codes. The analog converter is modelled by a timed stand-in. That model takes a fixed, parameterised number of clock cycles, then samples the selected channel from a flat input vector. Register map (4-bit byte address): 0 channel select, 1 result high, 2 result low, 3 interrupt control, 4 interrupt status, 8 and up one DAC register per channel. Any other address reads as zero.

Top module: `adc_host_regs`

## Requirements
- R1: Writing address 0 latches `bus_wdata[CH_W-1:0]` as the channel, which reads back zero-extended at address 0. The busy flag (bit 7 of address 1) reads 1 from the cycle after the write.
- R2: The busy flag stays set for exactly CONV_CYCLES clock edges counted from the write edge. It reads 0 after the CONV_CYCLES-th edge.
- R3: At the end of a conversion the selected channel's sample is captured. Address 1 reads {busy, zeros, sample[RES_W-1:8]}. Address 2 reads sample[7:0].
- R4: A finished conversion sets the pending request only if bit 0 of address 3 (interrupt enable, readable back) is 1. `irq_o` is the pending request, active high.
- R5: Bit 0 of address 4 reads the pending request. Its other bits read 0.
- R6: A read strobe at address 2 clears the pending request on that edge. A read at address 1 leaves it unchanged.
- R7: A channel write during a running conversion discards that conversion. It restarts timing and sampling on the new channel, so no early completion occurs.
- R8: Both result bytes keep the previous conversion's value for the whole of a later conversion. They change together at its end.
- R9: A write to address 8+k (k < DAC_CH) updates byte k of `dac_out` on that edge and can be read back there. The other bytes are unchanged.
- R10: A synchronous reset clears the channel, the busy flag, the results, the interrupt enable, the pending request and all DAC bytes.
- R11: `irq_o` stays high with no bus activity until it is cleared by R6 or R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; the read side effects happen on the edge |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ain | input | CH_N*RES_W | Sample value for each channel, channel k at bits k*RES_W upward |
| irq_o | output | 1 | Level interrupt request |
| dac_out | output | DAC_CH*8 | Output codes, channel k at bits 8k upward |

## Verification
If the conversion counter is wrong, busy appears at address 1 too early or too late by a whole number of cycles. Each completion is checked on the exact edge it should occur. If the pending flag is corrupted, `irq_o` and address 4 disagree with the enable history within one cycle of a completion or a low-byte read. A broken result capture shows up as a torn high/low pair or a result that changes during a later conversion. The bench reads both bytes during and after each conversion to catch this.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CHSEL  = 4'h0,
        A_RES_HI = 4'h1,
        A_RES_LO = 4'h2,
        A_ICTL   = 4'h3,
        A_ISTAT  = 4'h4
    } reg_addr_e;

    localparam logic [ADDR_W-1:0] DAC_BASE = 4'h8;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    // busy flag on top, then the upper result bits
    function automatic logic [BYTE_W-1:0] hi_byte(input logic busy, input logic [6:0] upper);
        return {busy, upper};
    endfunction

endpackage

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
    parameter int CH_N        = 8,
    parameter int CH_W        = 3,
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 8000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [CH_W-1:0]       start_ch,
    input  logic [CH_N*RES_W-1:0] ain,
    output logic                  busy,
    output logic                  done,
    output logic [RES_W-1:0]      sample
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  ch_q;

    // a new start overrides a finishing conversion
    assign done   = busy && (cnt_q == LAST) && !start;
    assign sample = ain[ch_q*RES_W +: RES_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            ch_q  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            ch_q  <= start_ch;
        end else if (busy) begin
            if (cnt_q == LAST) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic en_wr,
    input  logic en_bit,
    input  logic done,
    input  logic ack,
    output logic ien,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (en_wr) ien <= en_bit;
            // a fresh completion wins over an acknowledge on the same edge
            if (done && ien)  pend <= 1'b1;
            else if (ack)     pend <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_dac_bank.sv
module adc_dac_bank #(
    parameter int DAC_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [3:0]           off,
    input  logic [7:0]           wdata,
    output logic [7:0]           rd_byte,
    output logic [DAC_CH*8-1:0]  dac_out
);
    for (genvar k = 0; k < DAC_CH; k++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                             dac_out[k*8 +: 8] <= '0;
            else if (wr && off == 4'(k))         dac_out[k*8 +: 8] <= wdata;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < DAC_CH; k++) begin
            if (off == 4'(k)) rd_byte = dac_out[k*8 +: 8];
        end
    end
endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
    import adc_regs_pkg::*;
#(
    parameter int CH_N        = 8,
    parameter int RES_W       = 12,
    parameter int DAC_CH      = 4,
    parameter int CONV_CYCLES = 8000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [3:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [CH_N*RES_W-1:0] ain,
    output logic                  irq_o,
    output logic [DAC_CH*8-1:0]   dac_out
);
    localparam int CH_W = (CH_N > 1) ? $clog2(CH_N) : 1;

    bus_req_t req;
    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    logic            chsel_wr, ictl_wr, lo_rd, dac_hit;
    logic [3:0]      dac_off;
    logic [CH_W-1:0] chan_q;
    logic [RES_W-1:0] res_q, sample;
    logic            busy, done, ien, pend;
    logic [7:0]      dac_rd;

    assign chsel_wr = req.wr && req.addr == A_CHSEL;
    assign ictl_wr  = req.wr && req.addr == A_ICTL;
    assign lo_rd    = req.rd && req.addr == A_RES_LO;
    assign dac_off  = req.addr - DAC_BASE;
    assign dac_hit  = (req.addr >= DAC_BASE) && (int'(dac_off) < DAC_CH);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            res_q  <= '0;
        end else begin
            if (chsel_wr) chan_q <= req.wdata[CH_W-1:0];
            if (done)     res_q  <= sample;
        end
    end

    adc_conv_model #(
        .CH_N(CH_N), .CH_W(CH_W), .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)
    ) u_conv (
        .clk(clk), .rst(rst), .start(chsel_wr), .start_ch(req.wdata[CH_W-1:0]),
        .ain(ain), .busy(busy), .done(done), .sample(sample)
    );

    adc_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .en_wr(ictl_wr), .en_bit(req.wdata[0]),
        .done(done), .ack(lo_rd), .ien(ien), .pend(pend)
    );

    adc_dac_bank #(.DAC_CH(DAC_CH)) u_dac (
        .clk(clk), .rst(rst), .wr(req.wr && dac_hit), .off(dac_off),
        .wdata(req.wdata), .rd_byte(dac_rd), .dac_out(dac_out)
    );

    assign irq_o = pend;

    always_comb begin
        bus_rdata = '0;
        if (dac_hit) begin
            bus_rdata = dac_rd;
        end else begin
            case (req.addr)
                A_CHSEL:  bus_rdata = 8'(chan_q);
                A_RES_HI: bus_rdata = hi_byte(busy, 7'(res_q >> 8));
                A_RES_LO: bus_rdata = res_q[7:0];
                A_ICTL:   bus_rdata = {7'd0, ien};
                A_ISTAT:  bus_rdata = {7'd0, pend};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk
    import adc_regs_pkg::*;
#(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [3:0]       bus_addr,
    input logic             busy,
    input logic             done,
    input logic             ien,
    input logic             irq_o,
    input logic [RES_W-1:0] res_q
);
    // R1: a channel write starts a conversion
    p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CHSEL) |=> busy);

    // R4: a request only rises when enabled
    p_irq_gated_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(ien));

    // R4: an enabled completion raises the request
    p_done_raises_r4: assert property (@(posedge clk) disable iff (rst)
        (done && ien) |=> irq_o);

    // R6: low-byte read acknowledges
    p_lo_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_RES_LO && !done) |=> !irq_o);

    // R8: result held while a conversion runs
    p_res_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(res_q));

    // R10: reset clears control state
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (!irq_o && !busy && !ien));
endmodule

bind adc_host_regs adc_host_regs_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .busy(busy), .done(done), .ien(ien), .irq_o(irq_o), .res_q(res_q)
);

// File: tb/adc_host_regs_test.sv
`timescale 1ns/1ps
module adc_host_regs_test;
    localparam int CH_N = 8, RES_W = 12, DAC_CH = 4, CONV = 24;

    logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [CH_N*RES_W-1:0] ain = '0;
    logic irq_o;
    logic [DAC_CH*8-1:0] dac_out;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_host_regs #(.CH_N(CH_N), .RES_W(RES_W), .DAC_CH(DAC_CH), .CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ain(ain), .irq_o(irq_o), .dac_out(dac_out)
    );

    function automatic logic [7:0] exp_hi(input logic b, input logic [RES_W-1:0] v);
        return {b, 3'b000, v[11:8]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic set_ain(input int ch, input logic [RES_W-1:0] v);
        ain[ch*RES_W +: RES_W] = v;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] d;
        logic [RES_W-1:0] v;
        logic [DAC_CH*8-1:0] exp_dac;
        void'($urandom(32'd7391));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R10: reset state
        chk("R10 irq", irq_o, 0);
        peek(4'h0, d); chk("R10 chsel", d, 0);
        peek(4'h1, d); chk("R10 hi", d, 0);
        peek(4'h2, d); chk("R10 lo", d, 0);
        peek(4'h3, d); chk("R10 ictl", d, 0);
        chk("R10 dac", dac_out, 0);

        // R1 R2 R4 R5: directed timing
        set_ain(5, 12'hABC);
        wr(4'h3, 8'h01);
        peek(4'h3, d); chk("R4 enable readback", d, 1);
        wr(4'h0, 8'h05);
        peek(4'h0, d); chk("R1 channel readback", d, 5);
        peek(4'h1, d); chk("R1 busy set", d[7], 1);
        repeat (CONV - 1) @(posedge clk);
        @(negedge clk);
        peek(4'h1, d); chk("R2 busy before last edge", d[7], 1);
        chk("R4 no early irq", irq_o, 0);
        @(negedge clk);
        peek(4'h1, d); chk("R3 hi byte", d, 8'h0A);
        peek(4'h2, d); chk("R3 lo byte", d, 8'hBC);
        chk("R4 irq raised", irq_o, 1);
        peek(4'h4, d); chk("R5 status", d, 1);

        // R11 R6
        repeat (10) @(posedge clk);
        @(negedge clk); chk("R11 irq held", irq_o, 1);
        rd(4'h1, d); chk("R6 hi read keeps irq", irq_o, 1);
        rd(4'h2, d); chk("R6 lo data", d, 8'hBC);
        chk("R6 irq cleared", irq_o, 0);
        peek(4'h4, d); chk("R5 status cleared", d, 0);

        // R8 hold during next conversion
        set_ain(2, 12'h123);
        wr(4'h0, 8'h02);
        repeat (5) @(negedge clk);
        peek(4'h1, d); chk("R8 hi held", d, 8'h8A);
        peek(4'h2, d); chk("R8 lo held", d, 8'hBC);
        repeat (CONV) @(negedge clk);
        peek(4'h1, d); chk("R8 hi new", d, 8'h01);
        peek(4'h2, d); chk("R8 lo new", d, 8'h23);
        rd(4'h2, d);

        // R7 restart
        set_ain(3, 12'h111); set_ain(6, 12'h666);
        wr(4'h0, 8'h03);
        repeat (10) @(posedge clk);
        wr(4'h0, 8'h06);
        repeat (CONV - 1) @(posedge clk);
        @(negedge clk);
        peek(4'h1, d); chk("R7 still busy", d[7], 1);
        chk("R7 no irq from dropped run", irq_o, 0);
        @(negedge clk);
        peek(4'h1, d); chk("R7 hi new channel", d, 8'h06);
        peek(4'h2, d); chk("R7 lo new channel", d, 8'h66);
        rd(4'h2, d);

        // R9 DAC
        exp_dac = '0;
        for (int k = 0; k < DAC_CH; k++) begin
            logic [7:0] b;
            b = 8'($urandom);
            wr(4'(8 + k), b);
            exp_dac[k*8 +: 8] = b;
            chk("R9 dac out", dac_out, exp_dac);
            peek(4'(8 + k), d); chk("R9 dac readback", d, b);
        end

        // random conversions: R2 R3 R4 R5 R6
        for (int it = 0; it < 16; it++) begin
            int ch, cyc;
            logic en;
            en = 1'($urandom);
            ch = int'($urandom % CH_N);
            for (int c = 0; c < CH_N; c++) set_ain(c, RES_W'($urandom));
            v = ain[ch*RES_W +: RES_W];
            wr(4'h3, {7'd0, en});
            wr(4'h0, 8'(ch));
            cyc = 0;
            peek(4'h1, d);
            while (d[7] && cyc < CONV + 5) begin
                @(negedge clk); cyc++; peek(4'h1, d);
            end
            chk("R2 conversion length", cyc, CONV);
            chk("R3 hi byte", d, exp_hi(1'b0, v));
            peek(4'h2, d); chk("R3 lo byte", d, v[7:0]);
            chk("R4 irq vs enable", irq_o, en);
            peek(4'h4, d); chk("R5 status vs enable", d, {7'd0, en});
            rd(4'h2, d);
            chk("R6 irq after lo read", irq_o, 0);
        end

        // R10 reset mid-operation
        wr(4'h3, 8'h01);
        wr(4'h0, 8'h04);
        repeat (CONV + 2) @(negedge clk);
        chk("R10 irq before reset", irq_o, 1);
        wr(4'h0, 8'h01);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R10 irq after reset", irq_o, 0);
        chk("R10 dac after reset", dac_out, 0);
        peek(4'h1, d); chk("R10 hi after reset", d, 0);
        peek(4'h3, d); chk("R10 ictl after reset", d, 0);
        peek(4'h0, d); chk("R10 chsel after reset", d, 0);

        summary();
    end
endmodule